// File: doc/BRIEF.md
# Precise-Interrupt History Buffer

This block keeps precise interrupt state for an out-of-order core that writes results into the register file as soon as they complete, without waiting for commit. Each issued instruction is given one slot, in program order. The slot holds the value that the destination register had *before* that instruction, together with the destination index and a completion flag. Completed slots leave the buffer in order from the oldest.

At issue, the previous value of the destination may not be known yet because an older producer is still in flight. In that case the slot stores the producer's tag and takes the value from the result broadcast that carries that tag. When an interrupt arrives, the buffer undoes the early register writes. It walks from the youngest live slot back to the oldest and sends each saved value to the register write port, one slot per cycle. Because the oldest saved value is written last, the register file returns to the state it had before the oldest instruction that has not retired. While this walk runs, the buffer accepts no issues, completions or retirements. A one-cycle done pulse marks the end of the walk, and the buffer is then empty.

Top module: `history_buffer`

## Requirements
- R1: After reset the buffer is empty and `iss_ready` is 1. Each accepted issue (`iss_valid` and `iss_ready` in the same cycle) takes the slot whose number appears on `iss_id` in that cycle. Slot numbers start at 0 and step by one, modulo 8, for each accepted issue.
- R2: When 8 slots are live, `iss_ready` is 0. An `iss_valid` in that state allocates nothing.
- R3: A slot saves `iss_old_value` when `iss_old_ready` is 1. Otherwise it saves the `cdb_value` of the first broadcast whose `cdb_tag` equals `iss_old_tag`. A broadcast in the issue cycle itself counts.
- R4: A completion (`cmp_valid`, `cmp_id`, `cmp_value`) for a slot with a destination drives `rf_we`=1, `rf_waddr`=destination and `rf_wdata`=`cmp_value` combinationally in the same cycle. A completion for a slot without a destination drives `rf_we`=0.
- R5: `ret_valid` is 1, with `ret_id` equal to the oldest slot, exactly in cycles where the oldest slot has completed. The earliest such cycle is the one after its completion. One slot retires per cycle, in order.
- R6: An `irq` sampled outside a rollback starts a rollback in the next cycle. In rollback cycle n (n = 1..k, with k live slots), the slot that is n-th youngest is processed, and its saved old value is written to its destination. After the rollback the register file holds its state from before the oldest slot that had not retired.
- R7: A slot without a destination, or one whose old value was never captured, writes nothing in its rollback cycle. It still uses that cycle.
- R8: In the `irq` cycle and during the rollback, `iss_ready` is 0. Completions and retirements are ignored, and the write port carries only restore writes.
- R9: `rb_done` pulses in rollback cycle k+1. In the next cycle the buffer is empty, `iss_ready` is 1, and `iss_id` equals the slot number of the oldest slot that was live when the rollback began.
- R10: `irq` asserted while `rb_busy` is 1 has no effect. `rb_busy` drops after the `rb_done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_has_dst | input | 1 | Issued instruction writes a register |
| iss_dst | input | 3 | Destination register index |
| iss_old_ready | input | 1 | Previous destination value is available |
| iss_old_value | input | 16 | Previous destination value |
| iss_old_tag | input | 4 | Tag of the producer of the previous value |
| iss_ready | output | 1 | Issue can be accepted |
| iss_id | output | 3 | Slot given to the issue |
| cdb_valid | input | 1 | Result broadcast valid |
| cdb_tag | input | 4 | Broadcast producer tag |
| cdb_value | input | 16 | Broadcast value |
| cmp_valid | input | 1 | Completion of a slot |
| cmp_id | input | 3 | Completing slot |
| cmp_value | input | 16 | Completed result |
| ret_valid | output | 1 | Oldest slot retires this cycle |
| ret_id | output | 3 | Retiring slot |
| irq | input | 1 | Interrupt request |
| rb_busy | output | 1 | Rollback in progress |
| rb_done | output | 1 | Rollback finished (one-cycle pulse) |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 3 | Register file write index |
| rf_wdata | output | 16 | Register file write data |

## Verification
Outputs with no register on their path (`iss_id`, `iss_ready`, the write port for completions, `ret_valid` once a flag is set) are sampled in the very cycle their stimulus is driven, 2 ns after the edge. A completion flag becomes visible as a retirement one cycle later, and an interrupt becomes visible as `rb_busy` one cycle later. Restore writes are logged at the falling edge of each rollback cycle. The bench counts rollback cycles from the `irq` edge and expects `rb_done` in cycle k+1 for every k from 0 to 8. The restored register file is then compared against a snapshot that the bench computes.

// File: rtl/hb_pkg.sv
`timescale 1ns/1ps
package hb_pkg;

  typedef enum logic {
    HB_RUN  = 1'b0,
    HB_ROLL = 1'b1
  } hb_mode_e;

  // circular pointer step forward
  function automatic int unsigned hb_wrap_inc(input int unsigned p, input int unsigned n);
    return (p + 1 >= n) ? 0 : p + 1;
  endfunction

  // circular pointer step backward
  function automatic int unsigned hb_wrap_dec(input int unsigned p, input int unsigned n);
    return (p == 0) ? n - 1 : p - 1;
  endfunction

endpackage

// File: rtl/hb_ctrl.sv
`timescale 1ns/1ps
module hb_ctrl #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_valid,
  input  logic             irq,
  input  logic             head_done,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic [IDX_W-1:0] undo_idx,
  output logic             iss_ready,
  output logic             iss_fire,
  output logic             ret_fire,
  output logic             undo_step,
  output logic             undo_done,
  output logic             halted,
  output logic             rolling
);
  import hb_pkg::*;

  hb_mode_e          mode_q;
  logic [CNT_W-1:0]  live_q;
  logic              full_w, empty_w;

  assign rolling   = (mode_q == HB_ROLL);
  assign full_w    = (live_q == CNT_W'(DEPTH));
  assign empty_w   = (live_q == '0);
  assign halted    = rolling || irq;
  assign iss_ready = !full_w && !halted;
  assign iss_fire  = iss_valid && iss_ready;
  assign ret_fire  = !halted && !empty_w && head_done;
  assign undo_step = rolling && !empty_w;
  assign undo_done = rolling && empty_w;
  assign undo_idx  = IDX_W'(hb_wrap_dec(32'(tail), DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= HB_RUN;
      head   <= '0;
      tail   <= '0;
      live_q <= '0;
    end else if (!rolling) begin
      if (irq) begin
        mode_q <= HB_ROLL;
      end else begin
        if (iss_fire) tail <= IDX_W'(hb_wrap_inc(32'(tail), DEPTH));
        if (ret_fire) head <= IDX_W'(hb_wrap_inc(32'(head), DEPTH));
        live_q <= live_q + CNT_W'(iss_fire) - CNT_W'(ret_fire);
      end
    end else if (undo_step) begin
      tail   <= undo_idx;
      live_q <= live_q - 1'b1;
    end else begin
      mode_q <= HB_RUN;
    end
  end

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    live_q <= CNT_W'(DEPTH));
  p_full_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (full_w && !ret_fire && !halted) |=> full_w);
  p_retire_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ret_fire |=> head == IDX_W'(hb_wrap_inc(32'($past(head)), DEPTH)));
  p_irq_starts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !rolling) |=> rolling);
  p_undo_shrinks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    undo_step |=> (live_q == $past(live_q) - 1'b1) && rolling);
  p_done_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    undo_done |=> !rolling && empty_w && (tail == head));
  p_quiet_roll_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rolling |=> $stable(head));

endmodule

// File: rtl/hb_slot.sv
`timescale 1ns/1ps
module hb_slot #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned RA_W   = 3,
  parameter int unsigned TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic              in_hasd,
  input  logic [RA_W-1:0]   in_dst,
  input  logic              in_ok,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [DATA_W-1:0] in_val,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_value,
  input  logic              mark_done,
  output logic              done,
  output logic              hasd,
  output logic [RA_W-1:0]   dst,
  output logic              ok,
  output logic [DATA_W-1:0] old
);
  logic [TAG_W-1:0] tag_q;
  logic             snoop_hit;

  assign snoop_hit = !ok && cdb_valid && (cdb_tag == tag_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done  <= 1'b0;
      hasd  <= 1'b0;
      dst   <= '0;
      ok    <= 1'b0;
      tag_q <= '0;
      old   <= '0;
    end else if (alloc) begin
      done  <= 1'b0;
      hasd  <= in_hasd;
      dst   <= in_dst;
      tag_q <= in_tag;
      if (in_ok) begin
        ok  <= 1'b1;
        old <= in_val;
      end else if (cdb_valid && cdb_tag == in_tag) begin
        ok  <= 1'b1;
        old <= cdb_value;
      end else begin
        ok  <= 1'b0;
      end
    end else begin
      if (mark_done) done <= 1'b1;
      if (snoop_hit) begin
        ok  <= 1'b1;
        old <= cdb_value;
      end
    end
  end

  p_fresh_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |=> !done);
  p_snoop_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!alloc && snoop_hit) |=> ok && (old == $past(cdb_value)));
  p_saved_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!alloc && ok) |=> ok && $stable(old));

endmodule

// File: rtl/hb_wport.sv
`timescale 1ns/1ps
module hb_wport #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned RA_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              undo_go,
  input  logic              undo_has,
  input  logic [RA_W-1:0]   undo_dst,
  input  logic [DATA_W-1:0] undo_val,
  input  logic              cmp_go,
  input  logic              cmp_has,
  input  logic [RA_W-1:0]   cmp_dst,
  input  logic [DATA_W-1:0] cmp_val,
  output logic              rf_we,
  output logic [RA_W-1:0]   rf_waddr,
  output logic [DATA_W-1:0] rf_wdata
);
  logic undo_wr, cmp_wr;

  assign undo_wr = undo_go && undo_has;
  assign cmp_wr  = !undo_go && cmp_go && cmp_has;

  always_comb begin
    rf_we    = undo_wr || cmp_wr;
    rf_waddr = undo_go ? undo_dst : cmp_dst;
    rf_wdata = undo_go ? undo_val : cmp_val;
  end

  p_single_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(undo_go && cmp_go));
  p_restore_skips_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (undo_go && !undo_has) |-> !rf_we);

endmodule

// File: rtl/history_buffer.sv
`timescale 1ns/1ps
module history_buffer #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned REG_N  = 8,
  parameter int unsigned TAG_W  = 4,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned RA_W  = $clog2(REG_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic              iss_has_dst,
  input  logic [RA_W-1:0]   iss_dst,
  input  logic              iss_old_ready,
  input  logic [DATA_W-1:0] iss_old_value,
  input  logic [TAG_W-1:0]  iss_old_tag,
  output logic              iss_ready,
  output logic [IDX_W-1:0]  iss_id,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_value,
  input  logic              cmp_valid,
  input  logic [IDX_W-1:0]  cmp_id,
  input  logic [DATA_W-1:0] cmp_value,
  output logic              ret_valid,
  output logic [IDX_W-1:0]  ret_id,
  input  logic              irq,
  output logic              rb_busy,
  output logic              rb_done,
  output logic              rf_we,
  output logic [RA_W-1:0]   rf_waddr,
  output logic [DATA_W-1:0] rf_wdata
);
  logic [IDX_W-1:0] head_w, tail_w, undo_idx_w;
  logic iss_fire_w, ret_fire_w, undo_step_w, undo_done_w, halted_w, rolling_w;
  logic cmp_go_w;

  logic              done_a [DEPTH];
  logic              hasd_a [DEPTH];
  logic [RA_W-1:0]   dst_a  [DEPTH];
  logic              ok_a   [DEPTH];
  logic [DATA_W-1:0] old_a  [DEPTH];

  hb_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .irq(irq),
    .head_done(done_a[head_w]), .head(head_w), .tail(tail_w), .undo_idx(undo_idx_w),
    .iss_ready(iss_ready), .iss_fire(iss_fire_w), .ret_fire(ret_fire_w),
    .undo_step(undo_step_w), .undo_done(undo_done_w), .halted(halted_w),
    .rolling(rolling_w)
  );

  assign cmp_go_w = cmp_valid && !halted_w;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic take_w;
    assign take_w = iss_fire_w && (tail_w == IDX_W'(g));
    hb_slot #(.DATA_W(DATA_W), .RA_W(RA_W), .TAG_W(TAG_W)) slot_i (
      .clk(clk), .rst_n(rst_n), .alloc(take_w),
      .in_hasd(iss_has_dst), .in_dst(iss_dst), .in_ok(iss_old_ready),
      .in_tag(iss_old_tag), .in_val(iss_old_value),
      .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
      .mark_done(cmp_go_w && (cmp_id == IDX_W'(g)) && !take_w),
      .done(done_a[g]), .hasd(hasd_a[g]), .dst(dst_a[g]), .ok(ok_a[g]), .old(old_a[g])
    );
  end

  hb_wport #(.DATA_W(DATA_W), .RA_W(RA_W)) wport_i (
    .clk(clk), .rst_n(rst_n),
    .undo_go(undo_step_w), .undo_has(hasd_a[undo_idx_w] && ok_a[undo_idx_w]),
    .undo_dst(dst_a[undo_idx_w]), .undo_val(old_a[undo_idx_w]),
    .cmp_go(cmp_go_w), .cmp_has(hasd_a[cmp_id]), .cmp_dst(dst_a[cmp_id]),
    .cmp_val(cmp_value),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
  );

  assign iss_id    = tail_w;
  assign ret_valid = ret_fire_w;
  assign ret_id    = head_w;
  assign rb_busy   = rolling_w;
  assign rb_done   = undo_done_w;

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rb_done |=> !rb_done && iss_ready);
  p_no_issue_in_roll_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rb_busy |-> !iss_ready && !ret_valid);

endmodule

// File: tb/history_buffer_tb_top.sv
`timescale 1ns/1ps
module history_buffer_tb_top;
  localparam int DEPTH = 8;
  localparam int NREG  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iss_valid, iss_has_dst, iss_old_ready, iss_ready;
  logic [2:0] iss_dst, iss_id, cmp_id, ret_id, rf_waddr;
  logic [15:0] iss_old_value, cdb_value, cmp_value, rf_wdata;
  logic [3:0] iss_old_tag, cdb_tag;
  logic cdb_valid, cmp_valid, ret_valid, irq, rb_busy, rb_done, rf_we;

  history_buffer #(.DEPTH(DEPTH), .DATA_W(16), .REG_N(NREG), .TAG_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_has_dst(iss_has_dst),
    .iss_dst(iss_dst), .iss_old_ready(iss_old_ready), .iss_old_value(iss_old_value),
    .iss_old_tag(iss_old_tag), .iss_ready(iss_ready), .iss_id(iss_id),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
    .cmp_valid(cmp_valid), .cmp_id(cmp_id), .cmp_value(cmp_value),
    .ret_valid(ret_valid), .ret_id(ret_id), .irq(irq), .rb_busy(rb_busy),
    .rb_done(rb_done), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
  );

  always #2.5 clk = ~clk;

  logic [15:0] arf  [NREG];
  logic [15:0] snap [NREG];
  int          e_hd [DEPTH];
  int          e_dst[DEPTH];
  int          e_ok [DEPTH];
  logic [15:0] e_old[DEPTH];
  int bhead, btail, bcount;
  int checks, errors;
  bit finished;
  int          rl_addr[$];
  logic [15:0] rl_data[$];
  int          ex_addr[$];
  logic [15:0] ex_data[$];

  // bench-side register file, written by the block's port
  always @(negedge clk) begin
    if (rst_n && rf_we) begin
      arf[rf_waddr] = rf_wdata;
      if (rb_busy) begin
        rl_addr.push_back(int'(rf_waddr));
        rl_data.push_back(rf_wdata);
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    iss_valid = 0; cmp_valid = 0; cdb_valid = 0; irq = 0;
  endtask

  task automatic take_snap();
    for (int r = 0; r < NREG; r++) snap[r] = arf[r];
  endtask

  task automatic issue(input int hd, input int d, input int rdy, input int tag);
    iss_valid = 1; iss_has_dst = hd[0]; iss_dst = d[2:0]; iss_old_ready = rdy[0];
    iss_old_value = arf[d]; iss_old_tag = tag[3:0];
    #1;
    check("R1", "iss_ready", int'(iss_ready), 1);
    check("R1", "iss_id", int'(iss_id), btail);
    e_hd[btail] = hd; e_dst[btail] = d; e_ok[btail] = rdy; e_old[btail] = arf[d];
    btail = (btail + 1) % DEPTH; bcount++;
    @(posedge clk); #1;
    iss_valid = 0;
  endtask

  task automatic complete(input int id, input logic [15:0] v);
    cmp_valid = 1; cmp_id = id[2:0]; cmp_value = v;
    #1;
    check("R4", "rf_we on completion", int'(rf_we), e_hd[id]);
    if (e_hd[id] != 0) begin
      check("R4", "rf_waddr", int'(rf_waddr), e_dst[id]);
      check("R4", "rf_wdata", int'(rf_wdata), int'(v));
    end
    @(posedge clk); #1;
    cmp_valid = 0;
  endtask

  task automatic rollback();
    int k_live;
    int done_at;
    k_live = bcount;
    ex_addr.delete(); ex_data.delete(); rl_addr.delete(); rl_data.delete();
    // youngest first; R7: slots without destination or saved value skipped
    for (int j = 0; j < k_live; j++) begin
      int idx;
      idx = (btail - 1 - j + 2 * DEPTH) % DEPTH;
      if (e_hd[idx] != 0 && e_ok[idx] != 0) begin
        ex_addr.push_back(e_dst[idx]);
        ex_data.push_back(e_old[idx]);
      end
    end
    irq = 1;
    #1;
    check("R8", "iss_ready in irq cycle", int'(iss_ready), 0);
    check("R6", "rb_busy before start", int'(rb_busy), 0);
    @(posedge clk); #1;
    done_at = -1;
    for (int n = 1; n <= DEPTH + 2; n++) begin
      cmp_valid = 1; cmp_id = bhead[2:0]; cmp_value = 16'hDEAD;
      iss_valid = 1; irq = 1;  // R10: irq held during rollback
      #1;
      check("R8", "iss_ready during rollback", int'(iss_ready), 0);
      check("R8", "ret_valid during rollback", int'(ret_valid), 0);
      if (rb_done) done_at = n;
      @(posedge clk); #1;
      if (done_at >= 0) break;
    end
    idle();
    #1;
    check("R9", "rb_done cycle", done_at, k_live + 1);
    check("R10", "rb_busy after done", int'(rb_busy), 0);
    check("R9", "iss_ready after done", int'(iss_ready), 1);
    check("R9", "iss_id after done", int'(iss_id), bhead);
    check("R7", "restore write count", rl_addr.size(), ex_addr.size());
    for (int i = 0; i < ex_addr.size() && i < rl_addr.size(); i++) begin
      check("R6", "restore addr order", rl_addr[i], ex_addr[i]);
      check("R6", "restore data", int'(rl_data[i]), int'(ex_data[i]));
    end
    btail = bhead; bcount = 0;
    @(posedge clk); #1;
  endtask

  initial begin
    #500000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int ida, idb, idc, idd;
    idle();
    iss_has_dst = 0; iss_dst = 0; iss_old_ready = 0; iss_old_value = 0; iss_old_tag = 0;
    cdb_tag = 0; cdb_value = 0; cmp_id = 0; cmp_value = 0;
    for (int r = 0; r < NREG; r++) arf[r] = 16'h0100 * r[15:0] + 16'h0011;
    bhead = 0; btail = 0; bcount = 0; checks = 0; errors = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    check("R1", "reset iss_ready", int'(iss_ready), 1);
    check("R1", "reset iss_id", int'(iss_id), 0);
    check("R5", "reset ret_valid", int'(ret_valid), 0);
    check("R9", "reset rb_busy", int'(rb_busy), 0);
    check("R4", "reset rf_we", int'(rf_we), 0);
    @(posedge clk); #1;

    // sweep of live counts 0..8, every slot position, completion order reversed
    for (int k = 0; k <= DEPTH; k++) begin
      take_snap();
      for (int i = 0; i < k; i++) issue((i % 3 != 2) ? 1 : 0, (i * 5 + k) % NREG, 1, 0);
      if (k == DEPTH) begin
        iss_valid = 1; iss_has_dst = 1; iss_dst = 3'd0; iss_old_ready = 1;
        iss_old_value = 16'hBAD0;
        #1;
        check("R2", "iss_ready when full", int'(iss_ready), 0);
        @(posedge clk); #1;
        iss_valid = 0;
      end
      for (int i = k - 1; i >= 0; i--) complete((bhead + i) % DEPTH, 16'h4000 + 16'(k * 16 + i));
      rollback();
      for (int r = 0; r < NREG; r++) check("R6", "register restored", int'(arf[r]), int'(snap[r]));
    end

    // in-order retirement
    take_snap();
    ida = btail; issue(1, 1, 1, 0);
    idb = btail; issue(1, 2, 1, 0);
    issue(1, 3, 1, 0);
    complete(idb, 16'h2222);
    #1 check("R5", "no retire while oldest incomplete", int'(ret_valid), 0);
    @(posedge clk); #1;
    complete(ida, 16'h1111);
    #1;
    check("R5", "oldest retires", int'(ret_valid), 1);
    check("R5", "retire id oldest", int'(ret_id), ida);
    @(posedge clk); #1;
    #1;
    check("R5", "second retires", int'(ret_valid), 1);
    check("R5", "retire id second", int'(ret_id), idb);
    @(posedge clk); #1;
    #1 check("R5", "third not complete", int'(ret_valid), 0);
    bhead = (bhead + 2) % DEPTH; bcount -= 2;
    @(posedge clk); #1;
    rollback();
    check("R6", "retired r1 kept", int'(arf[1]), 16'h1111);
    check("R6", "retired r2 kept", int'(arf[2]), 16'h2222);
    check("R6", "unretired r3 restored", int'(arf[3]), int'(snap[3]));

    // old values supplied through the broadcast
    take_snap();
    ida = btail; issue(1, 4, 1, 0);
    idb = btail; issue(1, 4, 0, 5);
    idc = btail;
    cdb_valid = 1; cdb_tag = 4'd7; cdb_value = 16'h7777;
    issue(1, 6, 0, 7);
    cdb_valid = 0;
    idd = btail; issue(1, 2, 0, 9);
    cdb_valid = 1; cdb_tag = 4'd5; cdb_value = 16'h5555;
    complete(ida, 16'h5555);
    cdb_valid = 0;
    e_ok[idb] = 1; e_old[idb] = 16'h5555;
    e_ok[idc] = 1; e_old[idc] = 16'h7777;
    e_ok[idd] = 0;
    rollback();
    check("R3", "r4 back to original", int'(arf[4]), int'(snap[4]));
    check("R3", "same-cycle capture restored", int'(arf[6]), 16'h7777);
    check("R7", "uncaptured slot wrote nothing", int'(arf[2]), int'(snap[2]));

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule